// File: doc/BRIEF.md
# Dual-Port Word Memory with Collision Flags

This block is a synchronous memory with two fully independent access ports, A and B, running on one shared clock. Either port can read or write any word. Each port registers its own output word, and a write shows the stored word on that port's output in the same cycle (write-first).

Both ports may enable an access to the same address on the same edge. If at least one of them writes, that is a collision, and the block resolves it in a defined way. It never produces unknown values. A port that reads while the other writes gets a per-port "bad" flag next to its output word. Two writes to one word clear that word's valid bit, and any later read of that word raises the reader's bad flag until a clean write sets the valid bit again.

Each port also has a synchronous output reset. It clears only that port's output register and flag, never the stored words. The block has no streaming data path, so it uses no valid/ready handshake. Every pin is a plain control or data signal that is sampled on each rising edge.

Top module: `dpr_ram`

## Requirements
- R1: While `rst_ni` is low, both output words and both bad flags are zero and every word's valid bit is set, so reading a never-written word gives bad = 0.
- R2: A port with enable = 1 and write-enable = 0 shows the addressed word on its output after that edge.
- R3: A port with enable = 1 and write-enable = 1 stores its data-in at its address and shows that same data-in with bad = 0 after that edge.
- R4: A port with enable = 0 keeps its output word and bad flag unchanged.
- R5: A port's output does not follow a later write to the same word by the other port. Only a new read on that port returns the new value.
- R6: If one port writes and the other reads the same address on the same edge, the write is stored, the writer shows its data with bad = 0, and the reader shows bad = 1.
- R7: If both ports write the same address on the same edge, each port shows its own data-in with bad = 0, and the word's valid bit is cleared, so a later read of that word shows bad = 1.
- R8: A later write to a word from one port alone sets its valid bit again, and a read then returns the new data with bad = 0.
- R9: Two reads of the same address on the same edge both return the stored word with bad = 0.
- R10: Output reset together with enable clears that port's output word and bad flag on the edge and leaves the stored words untouched.
- R11: Output reset with enable = 0 has no effect. The output holds its value.
- R12: Writes from both ports to different addresses on the same edge are both stored, and neither port raises its bad flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_ni | input | 1 | Synchronous active-low block reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_orst | input | 1 | Port A output reset (acts only with a_en) |
| a_addr | input | AW (8) | Port A word address |
| a_wdata | input | DW (16) | Port A write data |
| a_rdata | output | DW (16) | Port A registered output word |
| a_bad | output | 1 | Port A output-invalid flag |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_orst | input | 1 | Port B output reset (acts only with b_en) |
| b_addr | input | AW (8) | Port B word address |
| b_wdata | input | DW (16) | Port B write data |
| b_rdata | output | DW (16) | Port B registered output word |
| b_bad | output | 1 | Port B output-invalid flag |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it are sampled. This holds for read data, write mirrors, bad flags, output resets and holds alike, and a word poisoned on one edge is seen by a read issued on the next edge. The driver sets inputs on the falling edge and tags each expected item with the index of the next rising edge. The monitor compares only items whose edge has just passed, and it samples shortly after that edge. Where the rules leave an output word undefined, only the bad flag is compared: for the reader in a write-read collision, and for any read of a poisoned word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Per-port access controls sampled on each edge.
  typedef struct packed {
    logic en;
    logic we;
    logic orst;
  } dpr_ctl_t;

  // How the other port's access on this edge affects this port.
  typedef enum logic [1:0] {
    COL_NONE   = 2'd0,
    COL_RD_HIT = 2'd1,  // this port reads, the other writes the same word
    COL_WW     = 2'd2   // both ports write the same word
  } dpr_col_e;

  localparam int unsigned NPORT = 2;

endpackage

// File: rtl/dpr_collide.sv
module dpr_collide
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  dpr_ctl_t        ctl_a,
  input  dpr_ctl_t        ctl_b,
  input  logic [AW-1:0]   addr_a,
  input  logic [AW-1:0]   addr_b,
  output dpr_col_e        kind_a,
  output dpr_col_e        kind_b,
  output logic            poison
);

  logic same;
  logic both_wr;

  assign same    = ctl_a.en && ctl_b.en && (addr_a == addr_b);
  assign both_wr = ctl_a.we && ctl_b.we;
  assign poison  = same && both_wr;

  always_comb begin
    kind_a = COL_NONE;
    kind_b = COL_NONE;
    if (same) begin
      if (both_wr) begin
        kind_a = COL_WW;
        kind_b = COL_WW;
      end else if (ctl_b.we) begin
        kind_a = COL_RD_HIT;
      end else if (ctl_a.we) begin
        kind_b = COL_RD_HIT;
      end
    end
  end

endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wd_a,
  input  logic          wr_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wd_b,
  input  logic          poison,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic          ok_a,
  output logic          ok_b
);

  logic [DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] word_ok;

  // Data array: no reset; port A is applied last so one value lands on a clash.
  always_ff @(posedge clk) begin
    if (wr_b) mem[addr_b] <= wd_b;
    if (wr_a) mem[addr_a] <= wd_a;
  end

  // Per-word valid bits: a double write poisons, a lone write heals.
  always_ff @(posedge clk) begin
    if (!rst_ni) begin
      word_ok <= '1;
    end else if (poison) begin
      word_ok[addr_a] <= 1'b0;
    end else begin
      if (wr_a) word_ok[addr_a] <= 1'b1;
      if (wr_b) word_ok[addr_b] <= 1'b1;
    end
  end

  // Contents before this edge; the port stage registers them.
  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];
  assign ok_a = word_ok[addr_a];
  assign ok_b = word_ok[addr_b];

endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out
  import dpr_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  dpr_ctl_t      ctl,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_word,
  input  logic          word_ok,
  input  dpr_col_e      kind,
  output logic [DW-1:0] dout,
  output logic          bad
);

  always_ff @(posedge clk) begin
    if (!rst_ni) begin
      dout <= '0;
      bad  <= 1'b0;
    end else if (ctl.en) begin
      if (ctl.orst) begin
        dout <= '0;
        bad  <= 1'b0;
      end else if (ctl.we) begin
        dout <= wdata;
        bad  <= 1'b0;
      end else begin
        dout <= mem_word;
        bad  <= (kind == COL_RD_HIT) || !word_ok;
      end
    end
  end

endmodule

// File: rtl/dpr_ram.sv
module dpr_ram
  import dpr_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          a_en,
  input  logic          a_we,
  input  logic          a_orst,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_bad,
  input  logic          b_en,
  input  logic          b_we,
  input  logic          b_orst,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_bad
);

  dpr_ctl_t        ctl   [NPORT];
  logic [AW-1:0]   addr  [NPORT];
  logic [DW-1:0]   wdat  [NPORT];
  logic [DW-1:0]   mword [NPORT];
  logic            wok   [NPORT];
  dpr_col_e        kind  [NPORT];
  logic [DW-1:0]   dout  [NPORT];
  logic            bad   [NPORT];
  logic            poison;

  assign ctl[0]  = '{en: a_en, we: a_we, orst: a_orst};
  assign ctl[1]  = '{en: b_en, we: b_we, orst: b_orst};
  assign addr[0] = a_addr;
  assign addr[1] = b_addr;
  assign wdat[0] = a_wdata;
  assign wdat[1] = b_wdata;

  dpr_collide #(.AW(AW)) u_col (
    .ctl_a  (ctl[0]),
    .ctl_b  (ctl[1]),
    .addr_a (addr[0]),
    .addr_b (addr[1]),
    .kind_a (kind[0]),
    .kind_b (kind[1]),
    .poison (poison)
  );

  dpr_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr_a   (ctl[0].en && ctl[0].we),
    .addr_a (addr[0]),
    .wd_a   (wdat[0]),
    .wr_b   (ctl[1].en && ctl[1].we),
    .addr_b (addr[1]),
    .wd_b   (wdat[1]),
    .poison (poison),
    .rd_a   (mword[0]),
    .rd_b   (mword[1]),
    .ok_a   (wok[0]),
    .ok_b   (wok[1])
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_out #(.DW(DW)) u_out (
      .clk      (clk),
      .rst_ni   (rst_ni),
      .ctl      (ctl[p]),
      .wdata    (wdat[p]),
      .mem_word (mword[p]),
      .word_ok  (wok[p]),
      .kind     (kind[p]),
      .dout     (dout[p]),
      .bad      (bad[p])
    );
  end

  assign a_rdata = dout[0];
  assign a_bad   = bad[0];
  assign b_rdata = dout[1];
  assign b_bad   = bad[1];

endmodule

// File: rtl/dpr_ram_chk.sv
module dpr_ram_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          a_en,
  input logic          a_we,
  input logic          a_orst,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          a_bad,
  input logic          b_en,
  input logic          b_we,
  input logic          b_orst,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic          b_bad
);

  // R3 / R7: a write mirrors its own data-in, flag low
  a_r3_mirror_a: assert property (@(posedge clk) disable iff (!rst_ni)
    a_en && a_we && !a_orst |=> a_rdata == $past(a_wdata) && !a_bad);
  a_r3_mirror_b: assert property (@(posedge clk) disable iff (!rst_ni)
    b_en && b_we && !b_orst |=> b_rdata == $past(b_wdata) && !b_bad);

  // R4 / R11: disabled port holds
  a_r4_hold_a: assert property (@(posedge clk) disable iff (!rst_ni)
    !a_en |=> $stable(a_rdata) && $stable(a_bad));
  a_r4_hold_b: assert property (@(posedge clk) disable iff (!rst_ni)
    !b_en |=> $stable(b_rdata) && $stable(b_bad));

  // R6: the reader in a write-read clash is flagged
  a_r6_reader_a: assert property (@(posedge clk) disable iff (!rst_ni)
    a_en && !a_we && !a_orst && b_en && b_we && a_addr == b_addr |=> a_bad);
  a_r6_reader_b: assert property (@(posedge clk) disable iff (!rst_ni)
    b_en && !b_we && !b_orst && a_en && a_we && a_addr == b_addr |=> b_bad);

  // R10: output reset with enable clears word and flag
  a_r10_orst_a: assert property (@(posedge clk) disable iff (!rst_ni)
    a_en && a_orst |=> a_rdata == '0 && !a_bad);
  a_r10_orst_b: assert property (@(posedge clk) disable iff (!rst_ni)
    b_en && b_orst |=> b_rdata == '0 && !b_bad);

endmodule

bind dpr_ram dpr_ram_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_ni),
  .a_en    (a_en),
  .a_we    (a_we),
  .a_orst  (a_orst),
  .a_addr  (a_addr),
  .a_wdata (a_wdata),
  .a_rdata (a_rdata),
  .a_bad   (a_bad),
  .b_en    (b_en),
  .b_we    (b_we),
  .b_orst  (b_orst),
  .b_addr  (b_addr),
  .b_wdata (b_wdata),
  .b_rdata (b_rdata),
  .b_bad   (b_bad)
);

// File: tb/tb_dpr_ram.sv
`timescale 1ns/1ps
module tb_dpr_ram;

  localparam int DW = 16;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a_en = 0, a_we = 0, a_orst = 0, b_en = 0, b_we = 0, b_orst = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_bad, b_bad;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          due;
    bit          port;   // 0 = A, 1 = B
    bit          chk_d;
    logic [DW-1:0] d;
    bit          f;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpr_ram #(.DW(DW), .DEPTH(256)) dut (
    .clk(clk), .rst_ni(rst_ni),
    .a_en(a_en), .a_we(a_we), .a_orst(a_orst), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_bad(a_bad),
    .b_en(b_en), .b_we(b_we), .b_orst(b_orst), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_bad(b_bad)
  );

  task automatic drive(input logic ea, wa, ra, input logic [AW-1:0] aa,
                       input logic [DW-1:0] da,
                       input logic eb, wb, rb, input logic [AW-1:0] ab,
                       input logic [DW-1:0] db);
    @(negedge clk);
    a_en = ea; a_we = wa; a_orst = ra; a_addr = aa; a_wdata = da;
    b_en = eb; b_we = wb; b_orst = rb; b_addr = ab; b_wdata = db;
  endtask

  task automatic idle();
    drive(0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
  endtask

  // Expected result for the edge that follows the current drive.
  task automatic expect_out(input bit port, input bit cd, input logic [DW-1:0] d,
                            input bit f, input string tag);
    exp_t e;
    e.due = cyc + 1; e.port = port; e.chk_d = cd; e.d = d; e.f = f; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops every item due at the edge just passed.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        logic [DW-1:0] ad;
        logic af;
        e = q.pop_front();
        ad = e.port ? b_rdata : a_rdata;
        af = e.port ? b_bad : a_bad;
        checks++;
        if (e.due != cyc || (e.chk_d && ad !== e.d) || af !== e.f) begin
          errors++;
          $display("FAIL %s port %s: actual data %h bad %b edge %0d, expected data %h bad %b edge %0d",
                   e.tag, e.port ? "B" : "A", ad, af, cyc, e.d, e.f, e.due);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual no completion, expected completion within 5000 edges");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk); rst_ni = 1'b1;

    // R1: outputs zero after reset; unwritten word reads as valid
    idle();
    expect_out(0, 1, 16'h0000, 0, "R1");
    expect_out(1, 1, 16'h0000, 0, "R1");
    drive(1, 0, 0, 8'd100, '0, 1, 0, 0, 8'd101, '0);
    expect_out(0, 0, '0, 0, "R1");
    expect_out(1, 0, '0, 0, "R1");

    // R3: plain write mirrors data-in
    drive(1, 1, 0, 8'd5, 16'h1111, 0, 0, 0, '0, '0);
    expect_out(0, 1, 16'h1111, 0, "R3");

    // R12: writes to distinct addresses on one edge
    drive(1, 1, 0, 8'd255, 16'h3333, 1, 1, 0, 8'd9, 16'h2222);
    expect_out(0, 1, 16'h3333, 0, "R12");
    expect_out(1, 1, 16'h2222, 0, "R12");

    // R2 / R12: read back both
    drive(1, 0, 0, 8'd9, '0, 1, 0, 0, 8'd5, '0);
    expect_out(0, 1, 16'h2222, 0, "R2");
    expect_out(1, 1, 16'h1111, 0, "R2");

    // R4: disabled ports hold
    idle();
    expect_out(0, 1, 16'h2222, 0, "R4");
    expect_out(1, 1, 16'h1111, 0, "R4");

    // R5: B keeps old value after A rewrites, then a fresh read updates
    drive(1, 1, 0, 8'd5, 16'h4444, 0, 0, 0, '0, '0);
    expect_out(0, 1, 16'h4444, 0, "R5");
    expect_out(1, 1, 16'h1111, 0, "R5");
    drive(0, 0, 0, '0, '0, 1, 0, 0, 8'd5, '0);
    expect_out(1, 1, 16'h4444, 0, "R5");

    // R6: A writes, B reads the same word
    drive(1, 1, 0, 8'd9, 16'h5555, 1, 0, 0, 8'd9, '0);
    expect_out(0, 1, 16'h5555, 0, "R6");
    expect_out(1, 0, '0, 1, "R6");
    drive(0, 0, 0, '0, '0, 1, 0, 0, 8'd9, '0);
    expect_out(1, 1, 16'h5555, 0, "R6");

    // R7: both write the same word
    drive(1, 1, 0, 8'd20, 16'hAAAA, 1, 1, 0, 8'd20, 16'hBBBB);
    expect_out(0, 1, 16'hAAAA, 0, "R7");
    expect_out(1, 1, 16'hBBBB, 0, "R7");
    drive(1, 0, 0, 8'd20, '0, 0, 0, 0, '0, '0);
    expect_out(0, 0, '0, 1, "R7");

    // R8: lone write heals the word
    drive(0, 0, 0, '0, '0, 1, 1, 0, 8'd20, 16'h7777);
    expect_out(1, 1, 16'h7777, 0, "R8");
    drive(1, 0, 0, 8'd20, '0, 0, 0, 0, '0, '0);
    expect_out(0, 1, 16'h7777, 0, "R8");

    // R9: two reads of one word
    drive(1, 0, 0, 8'd255, '0, 1, 0, 0, 8'd255, '0);
    expect_out(0, 1, 16'h3333, 0, "R9");
    expect_out(1, 1, 16'h3333, 0, "R9");

    // R10: output reset with enable, memory untouched
    drive(1, 0, 1, 8'd5, '0, 0, 0, 0, '0, '0);
    expect_out(0, 1, 16'h0000, 0, "R10");
    drive(1, 0, 0, 8'd5, '0, 0, 0, 0, '0, '0);
    expect_out(0, 1, 16'h4444, 0, "R10");

    // R11: output reset without enable is ignored
    drive(0, 0, 1, 8'd5, '0, 0, 0, 1, '0, '0);
    expect_out(0, 1, 16'h4444, 0, "R11");
    expect_out(1, 1, 16'h3333, 0, "R11");

    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule